// File: doc/BRIEF.md
# Inter-VM Doorbell Interrupt Register Block

This block is the software-visible register set of a shared-memory messaging device. A host driver reaches it through a 32-bit register port that decodes a 256-byte window. The block holds four registers:

- an interrupt enable mask;
- an interrupt status word that clears when it is read;
- a read-only peer identity, which a management input loads;
- a doorbell offset that stores nothing.

A write to the doorbell offset becomes a single-cycle outgoing message. Its upper half names the destination peer and its lower half names the vector.

Notifications that arrive from other peers set bit 0 of the status word. The block drives a level interrupt while any status bit is enabled by the mask. When the block is built for standalone use it never receives an identity, and it never sends doorbell messages.

Top module: `peer_bell_regs`

## Requirements
- R1: After reset the mask reads 0, the status reads 0 and the interrupt output is low. The identity register reads 0xFFFFFFFF, or 0 when the block is built standalone.
- R2: Registers sit at these byte offsets: mask 0x00, status 0x04, identity 0x08, doorbell 0x0C. Every other offset in the 8-bit address space (unaligned ones included) reads 0 and ignores writes. Read data appears with rd_valid on the cycle after the request.
- R3: The mask register is fully writable, so writing 0xFFFFFFFF reads back as 0xFFFFFFFF.
- R4: A write to the status offset loads the written word. A read of status returns the current value and then leaves status at 0.
- R5: Writes to the identity offset have no effect. When id_valid is high, the identity register loads id_in zero-extended to 32 bits.
- R6: With STANDALONE=1, the identity register always reads 0 and id_valid has no effect.
- R7: A write to the doorbell offset while an identity is assigned drives bell_valid high for exactly the next cycle. bell_dest then equals wdata[31:16] and bell_vector equals wdata[15:0]. A read of the doorbell offset returns 0 and changes no register.
- R8: A doorbell write made while no identity has been assigned produces no pulse. This always holds in standalone builds.
- R9: When peer_event is high, status bit 0 is set on the next cycle. If a status read happens in the same cycle, the read returns the old value and bit 0 is still set afterwards.
- R10: irq is high exactly when (status & mask) was nonzero on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| id_valid | input | 1 | Load the identity register |
| id_in | input | 16 | Identity value to load |
| peer_event | input | 1 | Incoming notification for vector 0 |
| bell_valid | output | 1 | Outgoing doorbell message strobe |
| bell_dest | output | 16 | Destination peer of the message |
| bell_vector | output | 16 | Vector number of the message |
| irq | output | 1 | Level interrupt |

## Verification
Some internal faults can only be seen through the ports. A status word that was not cleared, or a notification that was dropped, shows up on the next status read, and also on irq one cycle after the register changes. A corrupted identity changes the identity read, and it also turns doorbell pulses on or off on the cycle after a doorbell write. A behavioural model compares every output on every cycle, so a divergence is reported on the cycle it first becomes visible.

// File: rtl/pb_pkg.sv
package pb_pkg;

    localparam int PB_DW  = 32;
    localparam int PB_IDW = 16;

    localparam int unsigned OFS_MASK = 32'h00;
    localparam int unsigned OFS_STAT = 32'h04;
    localparam int unsigned OFS_POS  = 32'h08;
    localparam int unsigned OFS_BELL = 32'h0C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STAT,
        SEL_POS,
        SEL_BELL
    } pb_sel_e;

    typedef struct packed {
        logic [PB_IDW-1:0] dest;
        logic [PB_IDW-1:0] vector;
    } bell_msg_t;

    function automatic pb_sel_e pb_decode(input int unsigned ofs);
        case (ofs)
            OFS_MASK: return SEL_MASK;
            OFS_STAT: return SEL_STAT;
            OFS_POS:  return SEL_POS;
            OFS_BELL: return SEL_BELL;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pb_status.sv
module pb_status
    import pb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [PB_DW-1:0] wdata,
    input  logic             evt,
    output logic [PB_DW-1:0] status_q
);
    logic [PB_DW-1:0] status_d;

    always_comb begin
        status_d = status_q;
        if (wr_en)
            status_d = wdata;
        else if (rd_en)
            status_d = '0;
        if (evt)
            status_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end
endmodule

// File: rtl/pb_position.sv
module pb_position
    import pb_pkg::*;
#(
    parameter bit STANDALONE = 1'b0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              id_valid,
    input  logic [PB_IDW-1:0] id_in,
    output logic [PB_DW-1:0]  pos_q,
    output logic              assigned
);
    localparam logic [PB_DW-1:0] POS_RST = STANDALONE ? '0 : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= POS_RST;
            assigned <= 1'b0;
        end else if (!STANDALONE && id_valid) begin
            pos_q    <= PB_DW'(id_in);
            assigned <= 1'b1;
        end
    end
endmodule

// File: rtl/pb_bell.sv
module pb_bell
    import pb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [PB_DW-1:0] wdata,
    output logic             msg_valid,
    output bell_msg_t        msg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_q     <= '0;
        end else begin
            msg_valid <= fire;
            msg_q     <= fire ? bell_msg_t'(wdata) : '0;
        end
    end
endmodule

// File: rtl/peer_bell_regs.sv
module peer_bell_regs
    import pb_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit STANDALONE = 1'b0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PB_DW-1:0]  req_wdata,
    output logic              rd_valid,
    output logic [PB_DW-1:0]  rd_data,
    input  logic              id_valid,
    input  logic [PB_IDW-1:0] id_in,
    input  logic              peer_event,
    output logic              bell_valid,
    output logic [PB_IDW-1:0] bell_dest,
    output logic [PB_IDW-1:0] bell_vector,
    output logic              irq
);
    pb_sel_e          sel;
    logic             wr_any, rd_any;
    logic [PB_DW-1:0] mask_q, status_q, pos_q, rd_mux;
    logic             id_assigned;
    bell_msg_t        msg;

    assign sel    = pb_decode(32'(req_addr));
    assign wr_any = req_valid && req_write;
    assign rd_any = req_valid && !req_write;

    always_ff @(posedge clk) begin
        if (rst)                          mask_q <= '0;
        else if (wr_any && sel == SEL_MASK) mask_q <= req_wdata;
    end

    pb_status u_status (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_any && sel == SEL_STAT),
        .rd_en    (rd_any && sel == SEL_STAT),
        .wdata    (req_wdata),
        .evt      (peer_event),
        .status_q (status_q)
    );

    pb_position #(.STANDALONE(STANDALONE)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .id_valid (id_valid),
        .id_in    (id_in),
        .pos_q    (pos_q),
        .assigned (id_assigned)
    );

    pb_bell u_bell (
        .clk       (clk),
        .rst       (rst),
        .fire      (wr_any && sel == SEL_BELL && id_assigned),
        .wdata     (req_wdata),
        .msg_valid (bell_valid),
        .msg_q     (msg)
    );

    assign bell_dest   = msg.dest;
    assign bell_vector = msg.vector;

    always_comb begin
        case (sel)
            SEL_MASK: rd_mux = mask_q;
            SEL_STAT: rd_mux = status_q;
            SEL_POS:  rd_mux = pos_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            irq      <= 1'b0;
        end else begin
            rd_valid <= rd_any;
            rd_data  <= rd_any ? rd_mux : '0;
            irq      <= |(status_q & mask_q);
        end
    end
endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
    parameter int ADDR_W = 8
)(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              id_valid,
    input logic              peer_event,
    input logic              bell_valid,
    input logic              irq,
    input logic [31:0]       mask_q,
    input logic [31:0]       status_q,
    input logic [31:0]       pos_q,
    input logic              id_assigned
);
    logic wr_mask, rd_stat, wr_stat, wr_pos, wr_bell;
    assign wr_mask = req_valid &&  req_write && req_addr == ADDR_W'(8'h00);
    assign wr_stat = req_valid &&  req_write && req_addr == ADDR_W'(8'h04);
    assign rd_stat = req_valid && !req_write && req_addr == ADDR_W'(8'h04);
    assign wr_pos  = req_valid &&  req_write && req_addr == ADDR_W'(8'h08);
    assign wr_bell = req_valid &&  req_write && req_addr == ADDR_W'(8'h0C);

    a_r3_mask_loads: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> mask_q == $past(req_wdata));

    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !wr_stat && !peer_event) |=> status_q == 32'h0);

    a_r5_pos_ignores_write: assert property (@(posedge clk) disable iff (rst)
        (wr_pos && !id_valid) |=> $stable(pos_q));

    a_r7_bell_from_write: assert property (@(posedge clk) disable iff (rst)
        bell_valid |-> $past(wr_bell));

    a_r8_bell_needs_id: assert property (@(posedge clk) disable iff (rst)
        bell_valid |-> $past(id_assigned));

    a_r9_event_sets: assert property (@(posedge clk) disable iff (rst)
        peer_event |=> status_q[0]);

    a_r10_irq_high: assert property (@(posedge clk) disable iff (rst)
        (|(status_q & mask_q)) |=> irq);

    a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
        !(|(status_q & mask_q)) |=> !irq);
endmodule

bind peer_bell_regs pb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .id_valid    (id_valid),
    .peer_event  (peer_event),
    .bell_valid  (bell_valid),
    .irq         (irq),
    .mask_q      (mask_q),
    .status_q    (status_q),
    .pos_q       (pos_q),
    .id_assigned (id_assigned)
);

// File: tb/peer_bell_regs_bench.sv
module peer_bell_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        id_valid = 1'b0;
    logic [15:0] id_in = '0;
    logic        peer_event = 1'b0;

    logic        rd_valid, bell_valid, irq;
    logic [31:0] rd_data;
    logic [15:0] bell_dest, bell_vector;

    logic        s_rd_valid, s_bell_valid, s_irq;
    logic [31:0] s_rd_data;
    logic [15:0] s_bell_dest, s_bell_vector;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    peer_bell_regs u_peer_bell_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .id_valid(id_valid), .id_in(id_in),
        .peer_event(peer_event), .bell_valid(bell_valid), .bell_dest(bell_dest),
        .bell_vector(bell_vector), .irq(irq)
    );

    peer_bell_regs #(.STANDALONE(1'b1)) u_peer_bell_regs_solo (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(s_rd_valid),
        .rd_data(s_rd_data), .id_valid(id_valid), .id_in(id_in),
        .peer_event(peer_event), .bell_valid(s_bell_valid), .bell_dest(s_bell_dest),
        .bell_vector(s_bell_vector), .irq(s_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model of the main instance
    logic [31:0] m_mask, m_status, m_pos, m_rd_data;
    logic        m_has_id, m_rd_valid, m_bell_v, m_irq;
    logic [15:0] m_dest, m_vec;

    always @(posedge clk) begin
        if (rst) begin
            m_mask <= 0; m_status <= 0; m_pos <= 32'hFFFF_FFFF; m_has_id <= 0;
            m_rd_valid <= 0; m_rd_data <= 0; m_bell_v <= 0; m_irq <= 0;
            m_dest <= 0; m_vec <= 0;
        end else begin
            logic [31:0] nst;
            logic [31:0] rv;
            nst = m_status;
            rv  = 0;
            if (req_valid && !req_write) begin
                if (req_addr == 8'h00) rv = m_mask;
                if (req_addr == 8'h04) begin rv = m_status; nst = 0; end
                if (req_addr == 8'h08) rv = m_pos;
            end
            if (req_valid && req_write && req_addr == 8'h00) m_mask <= req_wdata;
            if (req_valid && req_write && req_addr == 8'h04) nst = req_wdata;
            if (peer_event) nst = nst | 32'h1;
            m_status   <= nst;
            m_rd_valid <= req_valid && !req_write;
            m_rd_data  <= rv;
            if (id_valid) begin m_pos <= {16'h0, id_in}; m_has_id <= 1; end
            m_bell_v <= req_valid && req_write && req_addr == 8'h0C && m_has_id;
            m_dest   <= req_wdata[31:16];
            m_vec    <= req_wdata[15:0];
            m_irq    <= (m_status & m_mask) != 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 rd_valid", 32'(rd_valid), 32'(m_rd_valid));
            if (m_rd_valid) chk("R2 rd_data", rd_data, m_rd_data);
            chk("R7 bell_valid", 32'(bell_valid), 32'(m_bell_v));
            if (m_bell_v) begin
                chk("R7 bell_dest", 32'(bell_dest), 32'(m_dest));
                chk("R7 bell_vector", 32'(bell_vector), 32'(m_vec));
            end
            chk("R10 irq", 32'(irq), 32'(m_irq));
        end
    end

    logic        cap_bell, cap_sbell;
    logic [15:0] cap_dest, cap_vec;

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        cap_bell = bell_valid; cap_sbell = s_bell_valid;
        cap_dest = bell_dest;  cap_vec   = bell_vector;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic [31:0] sd);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rd_data; sd = s_rd_data;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d, sd;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 bell", 32'(bell_valid), 0);
        do_read(8'h00, d, sd); chk("R1 mask", d, 0);
        do_read(8'h04, d, sd); chk("R1 status", d, 0);
        do_read(8'h08, d, sd); chk("R1 pos", d, 32'hFFFF_FFFF);
        chk("R6 solo pos", sd, 0);

        // R3 mask writable
        do_write(8'h00, 32'hFFFF_FFFF);
        do_read(8'h00, d, sd); chk("R3 mask", d, 32'hFFFF_FFFF);

        // R4 + R10 status load, irq, read clears
        do_write(8'h04, 32'h1);
        chk("R10 irq not yet", 32'(irq), 0);
        @(negedge clk); chk("R10 irq up", 32'(irq), 1);
        do_read(8'h04, d, sd); chk("R4 status value", d, 1);
        do_read(8'h04, d, sd); chk("R4 status cleared", d, 0);
        chk("R10 irq down", 32'(irq), 0);

        // R2 unlisted offsets
        do_write(8'h10, 32'h1234_5678);
        do_write(8'h02, 32'h0);
        do_read(8'h10, d, sd); chk("R2 unlisted read", d, 0);
        do_read(8'h02, d, sd); chk("R2 unaligned read", d, 0);
        do_read(8'hFC, d, sd); chk("R2 top read", d, 0);
        do_read(8'h00, d, sd); chk("R2 mask untouched", d, 32'hFFFF_FFFF);

        // R8 no pulse without identity
        do_write(8'h0C, 32'h0003_0000);
        chk("R8 no pulse", 32'(cap_bell), 0);

        // R5 identity read-only, loadable
        do_write(8'h08, 32'h1);
        do_read(8'h08, d, sd); chk("R5 pos ignores write", d, 32'hFFFF_FFFF);
        @(negedge clk); id_valid = 1; id_in = 16'h0005;
        @(negedge clk); id_valid = 0;
        do_read(8'h08, d, sd); chk("R5 pos loaded", d, 32'h5);
        chk("R6 solo pos stays", sd, 0);
        do_write(8'h08, 32'hDEAD_BEEF);
        do_read(8'h08, d, sd); chk("R5 pos still", d, 32'h5);

        // R7 doorbell encoding
        do_write(8'h0C, 32'h0003_0000);
        chk("R7 pulse", 32'(cap_bell), 1);
        chk("R7 dest", 32'(cap_dest), 3);
        chk("R7 vec", 32'(cap_vec), 0);
        chk("R6 solo no pulse", 32'(cap_sbell), 0);
        @(negedge clk); chk("R7 one cycle", 32'(bell_valid), 0);
        do_write(8'h0C, 32'hABCD_0007);
        chk("R7 dest2", 32'(cap_dest), 32'hABCD);
        chk("R7 vec2", 32'(cap_vec), 7);
        do_read(8'h0C, d, sd); chk("R7 bell reads zero", d, 0);
        chk("R7 read no pulse", 32'(bell_valid), 0);
        do_read(8'h04, d, sd); chk("R7 status untouched", d, 0);

        // R9 incoming notification
        @(negedge clk); peer_event = 1;
        @(negedge clk); peer_event = 0;
        do_read(8'h04, d, sd); chk("R9 event sets", d, 1);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 8'h04; peer_event = 1;
        @(negedge clk);
        req_valid = 0; peer_event = 0;
        chk("R9 read old value", rd_data, 0);
        do_read(8'h04, d, sd); chk("R9 set wins", d, 1);

        // R10 mask overlap patterns
        do_write(8'h00, 32'h0000_0004);
        do_write(8'h04, 32'h0000_0006);
        @(negedge clk); chk("R10 overlap", 32'(irq), 1);
        do_write(8'h00, 32'h0000_0001);
        @(negedge clk); chk("R10 no overlap", 32'(irq), 0);
        do_write(8'h00, 32'h0);
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule